// File: doc/BRIEF.md
# CPU-Side Banked Memory Mapper

This block sits on the CPU bus of a console cartridge whose program space is writable RAM. It watches the CPU address, data and read/write strobe and holds a small set of write-only control registers. From those it produces one translated physical address and a select line for each backing memory: a fixed 4 KiB scratch RAM, a 32 KiB work RAM seen through one 8 KiB window, a 512 KiB program RAM seen through four 8 KiB windows, and the loader firmware.

Two memory layouts exist, picked by one configuration bit. In game layout the work-RAM window sits at `$6000-$7FFF` and the four program windows cover `$8000-$FFFF`. In loader layout, used while a game image is being copied in, `$6000-$BFFF` reaches the first three program banks linearly and `$C000-$FFFF` selects the firmware. A software write-protect latch, loaded from an address bit of a write, gates the write enable of program RAM so that a loaded image cannot overwrite itself.

Register writes are committed on the falling edge of M2 while the CPU is writing. The edge is detected against the block clock, and the committed value is visible on the outputs from the clock edge that samples M2 low.

Top module: `cpu_bank_mapper`

## Requirements
- R1: After reset the `$E000-$FFFF` program window points at the last program bank (all ones, 63 with default parameters), the other three windows point at bank 0, the layout is loader layout and write-protect is clear.
- R2: A committed write to `$4504`, `$4505`, `$4506` or `$4507` stores data bits [5:0] as the bank for the window at `$8000`, `$A000`, `$C000` or `$E000` respectively; in game layout an access there drives `prg_sel` and `mem_addr = bank*8192 + (addr mod 8192)`.
- R3: A register write is committed only when M2 falls (high in one clock sample, low in the next) while `cpu_rw` is 0; a read cycle with an M2 fall, or a write strobe held with M2 steady, changes no register.
- R4: `$5000-$5FFF` drives `scr_sel` with `mem_addr = addr - $5000` in both layouts.
- R5: A committed write to `$4500` stores bit 6 as the layout (1 game, 0 loader) and bits [5:4] as the work-RAM bank; in game layout `$6000-$7FFF` drives `wram_sel` with `mem_addr = bank*8192 + (addr - $6000)`.
- R6: In loader layout `$6000-$BFFF` drives `prg_sel` with `mem_addr = addr - $6000` (banks 0 to 2 in order), and `$C000-$FFFF` drives `bios_sel` with `mem_addr = addr - $C000`.
- R7: A committed write to any address `$42FC-$42FF` loads address bit 1 into the write-protect latch; while it is 1, `prg_we` stays low.
- R8: `prg_we` is high exactly when `prg_sel` is high, `cpu_rw` is 0 and write-protect is clear; accesses to other memories never raise it.
- R9: At most one select is high at any time, and addresses `$0000-$4FFF` raise no select and give `mem_addr = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples M2 and updates registers |
| rst_n | input | 1 | Active-low synchronous reset |
| m2 | input | 1 | CPU bus phase clock; its falling edge commits register writes |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 for read, 0 for write |
| mem_addr | output | PRG_BANK_W+13 (19) | Translated physical address for the selected memory |
| scr_sel | output | 1 | Scratch RAM select |
| wram_sel | output | 1 | Work RAM select |
| prg_sel | output | 1 | Program RAM select |
| bios_sel | output | 1 | Loader firmware select |
| prg_we | output | 1 | Program RAM write enable |

## Verification
The bench builds the block with its default parameters: 6-bit program bank numbers and a 2-bit work-RAM bank. With these the reset bank of the top window is 63, so the all-ones default is told apart from any value written later, and bank 63 written into another window reaches the top of the 19-bit physical address. The 2-bit work-RAM field lets the bench place the window in banks 2 and 3 and see the bank bits land above the 13-bit offset.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  localparam int NUM_WIN = 4;
  localparam int WIN_W   = 13;
  localparam int SCR_W   = 12;
  localparam int BIOS_W  = 14;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_SCR,
    RGN_WRAM,
    RGN_PRG,
    RGN_BIOS
  } region_e;

  function automatic logic hit_cfg(input logic [15:0] a);
    return a == 16'h4500;
  endfunction

  function automatic logic hit_bank(input logic [15:0] a);
    return a[15:2] == 14'h1141;
  endfunction

  function automatic logic hit_wprot(input logic [15:0] a);
    return a[15:2] == 14'h10BF;
  endfunction

  function automatic logic [2:0] loader_slot(input logic [2:0] top3);
    return top3 - 3'd3;
  endfunction

endpackage

// File: rtl/cbm_m2_edge.sv
module cbm_m2_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic m2,
  input  logic cpu_rw,
  output logic wr_evt
);
  logic m2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= m2;
  end

  assign wr_evt = m2_q & ~m2 & ~cpu_rw;
endmodule

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W  = 6,
  parameter int WRAM_BANK_W = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_evt,
  input  logic [15:0]                          cpu_addr,
  input  logic [7:0]                           cpu_data,
  output logic [NUM_WIN-1:0][PRG_BANK_W-1:0]   prg_bank,
  output logic [WRAM_BANK_W-1:0]               wram_bank,
  output logic                                 game_mode,
  output logic                                 wprot
);
  localparam int SLOT_W = $clog2(NUM_WIN);
  localparam logic [PRG_BANK_W-1:0] LAST_BANK = {PRG_BANK_W{1'b1}};

  logic [SLOT_W-1:0] slot;
  assign slot = cpu_addr[SLOT_W-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [PRG_BANK_W-1:0] RST_BANK = (w == NUM_WIN - 1) ? LAST_BANK : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        prg_bank[w] <= RST_BANK;
      else if (wr_evt && hit_bank(cpu_addr) && slot == SLOT_W'(w))
        prg_bank[w] <= cpu_data[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wram_bank <= '0;
      game_mode <= 1'b0;
    end else if (wr_evt && hit_cfg(cpu_addr)) begin
      wram_bank <= cpu_data[4 +: WRAM_BANK_W];
      game_mode <= cpu_data[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      wprot <= 1'b0;
    else if (wr_evt && hit_wprot(cpu_addr))
      wprot <= cpu_addr[1];
  end
endmodule

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W  = 6,
  parameter int WRAM_BANK_W = 2,
  localparam int PHYS_W     = PRG_BANK_W + WIN_W
) (
  input  logic [15:0]                          cpu_addr,
  input  logic                                 cpu_rw,
  input  logic [NUM_WIN-1:0][PRG_BANK_W-1:0]   prg_bank,
  input  logic [WRAM_BANK_W-1:0]               wram_bank,
  input  logic                                 game_mode,
  input  logic                                 wprot,
  output region_e                              region,
  output logic [PHYS_W-1:0]                    phys,
  output logic                                 prg_we
);
  localparam int WRAM_W = WRAM_BANK_W + WIN_W;

  function automatic logic [PHYS_W-1:0] join_bank(input logic [PRG_BANK_W-1:0] b,
                                                  input logic [WIN_W-1:0] off);
    return {b, off};
  endfunction

  function automatic logic [PHYS_W-1:0] wram_phys(input logic [WRAM_BANK_W-1:0] b,
                                                  input logic [WIN_W-1:0] off);
    logic [WRAM_W-1:0] w;
    w = {b, off};
    return PHYS_W'(w);
  endfunction

  logic [2:0]        top3;
  logic [WIN_W-1:0]  off;
  logic [1:0]        win;
  assign top3 = cpu_addr[15:13];
  assign off  = cpu_addr[WIN_W-1:0];
  assign win  = cpu_addr[14:13];

  always_comb begin
    region = RGN_NONE;
    phys   = '0;
    if (cpu_addr[15:12] == 4'h5) begin
      region = RGN_SCR;
      phys   = PHYS_W'(cpu_addr[SCR_W-1:0]);
    end else if (game_mode) begin
      if (top3 == 3'd3) begin
        region = RGN_WRAM;
        phys   = wram_phys(wram_bank, off);
      end else if (cpu_addr[15]) begin
        region = RGN_PRG;
        phys   = join_bank(prg_bank[win], off);
      end
    end else begin
      if (top3 >= 3'd3 && top3 <= 3'd5) begin
        region = RGN_PRG;
        phys   = join_bank(PRG_BANK_W'(loader_slot(top3)), off);
      end else if (cpu_addr[15:14] == 2'b11) begin
        region = RGN_BIOS;
        phys   = PHYS_W'(cpu_addr[BIOS_W-1:0]);
      end
    end
  end

  assign prg_we = (region == RGN_PRG) && !cpu_rw && !wprot;
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANK_W  = 6,
  parameter int WRAM_BANK_W = 2,
  localparam int PHYS_W     = PRG_BANK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m2,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              cpu_rw,
  output logic [PHYS_W-1:0] mem_addr,
  output logic              scr_sel,
  output logic              wram_sel,
  output logic              prg_sel,
  output logic              bios_sel,
  output logic              prg_we
);
  logic                               wr_evt;
  logic [NUM_WIN-1:0][PRG_BANK_W-1:0] prg_bank;
  logic [WRAM_BANK_W-1:0]             wram_bank;
  logic                               game_mode;
  logic                               wprot;
  region_e                            region;

  cbm_m2_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .m2     (m2),
    .cpu_rw (cpu_rw),
    .wr_evt (wr_evt)
  );

  cbm_regs #(.PRG_BANK_W(PRG_BANK_W), .WRAM_BANK_W(WRAM_BANK_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt),
    .cpu_addr  (cpu_addr),
    .cpu_data  (cpu_data),
    .prg_bank  (prg_bank),
    .wram_bank (wram_bank),
    .game_mode (game_mode),
    .wprot     (wprot)
  );

  cbm_decode #(.PRG_BANK_W(PRG_BANK_W), .WRAM_BANK_W(WRAM_BANK_W)) u_dec (
    .cpu_addr  (cpu_addr),
    .cpu_rw    (cpu_rw),
    .prg_bank  (prg_bank),
    .wram_bank (wram_bank),
    .game_mode (game_mode),
    .wprot     (wprot),
    .region    (region),
    .phys      (mem_addr),
    .prg_we    (prg_we)
  );

  assign scr_sel  = (region == RGN_SCR);
  assign wram_sel = (region == RGN_WRAM);
  assign prg_sel  = (region == RGN_PRG);
  assign bios_sel = (region == RGN_BIOS);
endmodule

// File: rtl/cpu_bank_mapper_chk.sv
module cpu_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rw,
  input logic        scr_sel,
  input logic        wram_sel,
  input logic        prg_sel,
  input logic        bios_sel,
  input logic        prg_we,
  input logic        wr_evt,
  input logic        wprot,
  input logic        game_mode
);
  p_one_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scr_sel, wram_sel, prg_sel, bios_sel}));

  p_low_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h5000) |-> !(scr_sel || wram_sel || prg_sel || bios_sel));

  p_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prg_we |-> (prg_sel && !cpu_rw));

  p_we_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wprot |-> !prg_we);

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(game_mode));

  p_wprot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(wprot));

  p_bios_loader_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bios_sel |-> !game_mode);

  p_wram_game_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wram_sel |-> game_mode);
endmodule

bind cpu_bank_mapper cpu_bank_mapper_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_rw    (cpu_rw),
  .scr_sel   (scr_sel),
  .wram_sel  (wram_sel),
  .prg_sel   (prg_sel),
  .bios_sel  (bios_sel),
  .prg_we    (prg_we),
  .wr_evt    (wr_evt),
  .wprot     (wprot),
  .game_mode (game_mode)
);

// File: tb/sim_cpu_bank_mapper.sv
`timescale 1ns/1ps
module sim_cpu_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m2 = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rw = 1'b1;
  logic [18:0] mem_addr;
  logic        scr_sel, wram_sel, prg_sel, bios_sel, prg_we;

  always #2 clk = ~clk;

  cpu_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .m2(m2), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .mem_addr(mem_addr), .scr_sel(scr_sel), .wram_sel(wram_sel),
    .prg_sel(prg_sel), .bios_sel(bios_sel), .prg_we(prg_we)
  );

  typedef struct {
    int       ph;
    bit [3:0] sel;
    bit       we;
    string    tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  // bench model of the register state
  int m_bank[4];
  int m_wb;
  bit m_game;
  bit m_wp;

  function automatic void model_reset();
    m_bank[0] = 0; m_bank[1] = 0; m_bank[2] = 0; m_bank[3] = 63;
    m_wb = 0; m_game = 0; m_wp = 0;
  endfunction

  function automatic item_t model(input int a, input bit rw, input string tag);
    item_t it;
    it.ph = 0; it.sel = 4'b0000; it.tag = tag;
    if (a >= 'h5000 && a < 'h6000) begin
      it.sel = 4'b0001; it.ph = a - 'h5000;
    end else if (m_game) begin
      if (a >= 'h6000 && a < 'h8000) begin
        it.sel = 4'b0010; it.ph = m_wb * 8192 + (a - 'h6000);
      end else if (a >= 'h8000) begin
        it.sel = 4'b0100; it.ph = m_bank[(a - 'h8000) / 8192] * 8192 + (a % 8192);
      end
    end else begin
      if (a >= 'h6000 && a < 'hC000) begin
        it.sel = 4'b0100; it.ph = a - 'h6000;
      end else if (a >= 'hC000) begin
        it.sel = 4'b1000; it.ph = a - 'hC000;
      end
    end
    it.we = (it.sel == 4'b0100) && !rw && !m_wp;
    return it;
  endfunction

  task automatic probe(input int a, input bit rw, input string tag);
    @(posedge clk); #1;
    m2 = 1'b1; cpu_addr = a[15:0]; cpu_rw = rw;
    q.push_back(model(a, rw, tag));
  endtask

  task automatic reg_write(input int a, input int d, input bit rw);
    @(posedge clk); #1;
    cpu_addr = a[15:0]; cpu_data = d[7:0]; cpu_rw = rw; m2 = 1'b1;
    @(posedge clk); #1;
    m2 = 1'b0;
    @(posedge clk); #1;
    m2 = 1'b1; cpu_rw = 1'b1;
    if (!rw) begin
      if (a == 'h4500) begin m_wb = (d >> 4) & 3; m_game = d[6]; end
      else if (a >= 'h4504 && a <= 'h4507) m_bank[a - 'h4504] = d & 63;
      else if (a >= 'h42FC && a <= 'h42FF) m_wp = a[1];
    end
  endtask

  // monitor: pops expectations and compares mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      bit [3:0] s;
      e = q.pop_front();
      s = {bios_sel, prg_sel, wram_sel, scr_sel};
      checks++;
      if (s !== e.sel || int'(mem_addr) !== e.ph || prg_we !== e.we) begin
        fails++;
        $display("FAIL %s: sel=%b addr=%h we=%b expected sel=%b addr=%h we=%b",
                 e.tag, s, mem_addr, prg_we, e.sel, e.ph[18:0], e.we);
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 R9 R4 R6: state straight after reset (loader layout)
    probe('h0000, 1, "R9 low unmapped");
    probe('h4500, 1, "R9 register space");
    probe('h5123, 1, "R4 scratch");
    probe('h6000, 1, "R6 loader bank0");
    probe('hA010, 1, "R6 loader bank2");
    probe('hC000, 1, "R6 bios base");
    probe('hFFFF, 1, "R6 bios top");
    // R8 writes into program RAM unprotected
    probe('h7000, 0, "R8 write enable");
    probe('h5000, 0, "R8 scratch write no we");
    // R7 write-protect latch via address bit 1
    reg_write('h42FE, 'h00, 0);
    probe('h7000, 0, "R7 protected");
    reg_write('h42FD, 'hFF, 0);
    probe('h7000, 0, "R7 unprotected");
    // R5 R1 game layout, reset bank defaults
    reg_write('h4500, 'h60, 0);
    probe('h6004, 1, "R5 wram bank2");
    probe('hE123, 1, "R1 last bank default");
    probe('h8000, 1, "R1 bank0 default");
    probe('hA000, 1, "R1 bank0 default win1");
    // R2 bank registers
    reg_write('h4504, 'h05, 0);
    reg_write('h4505, 'h2A, 0);
    reg_write('h4506, 'h3F, 0);
    reg_write('h4507, 'h11, 0);
    probe('h8001, 1, "R2 win0");
    probe('hBFFF, 1, "R2 win1");
    probe('hC100, 1, "R2 win2");
    probe('hFFFE, 1, "R2 win3");
    // R3 no commit without M2 fall or on a read
    probe('h4504, 0, "R3 write strobe no edge");
    probe('h4504, 0, "R3 write strobe no edge");
    reg_write('h4504, 'h22, 1);
    probe('h8000, 1, "R3 bank unchanged");
    reg_write('h4500, 'h00, 1);
    probe('h6000, 1, "R3 layout unchanged");
    // R6 R5 back to loader, then game with bank3
    reg_write('h4500, 'h30, 0);
    probe('h6000, 1, "R6 loader again");
    probe('h5FFF, 1, "R4 scratch top");
    reg_write('h4500, 'h70, 0);
    probe('h7FFF, 1, "R5 wram bank3");
    probe('h6000, 0, "R8 wram write no we");
    probe('h9000, 0, "R8 game prg write");
    reg_write('h42FF, 'h00, 0);
    probe('h9000, 0, "R7 game protected");
    probe('h4FFF, 1, "R9 below scratch");

    wait (q.size() == 0);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule